// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter with Byte Queue

This block is the transmit half of an asynchronous serial port. It sits on a simple register bus. Software writes bytes into a data register. The bytes go into a 32-entry first-in first-out queue. A framer takes them out one at a time and sends them on a single output wire. Each byte becomes a ten-bit frame: a low start bit, the eight data bits with the least significant bit first, and a high stop bit. Frames that follow one another leave no idle time between them. When nothing is queued the line rests high.

Bit timing comes from an external `baud_tick` strobe. The parameter `TICK_DIV` sets how many strobes make one bit time. The default of 1 means one strobe per bit. A value of 16 lets the block take an oversampling strobe and divide it down internally.

Software controls the block through two registers. A control register holds two bits, a master enable and a transmit enable, and both must be set for frames to start. A flag register reports whether the queue is full, whether it is empty, and whether the transmitter is busy. A driver spins on the full flag before each write. It watches the busy flag to learn when the last stop bit has left the wire. A write to the data register while the queue is full is dropped.

Top module: `uart_tx_mmio`

## Requirements
- R1: Each frame is the start bit 0, then data bits 0 through 7 in that order, then a stop bit 1. Each bit holds `tx_out` for exactly one bit period, which is `TICK_DIV` strobes of `baud_tick`.
- R2: When no frame is in progress, `tx_out` is 1.
- R3: A write to offset 0x000 puts `bus_wdata[7:0]` into the queue. Bits 31:8 of the written word are ignored.
- R4: The queue holds up to 32 bytes and sends them in the order written. A data write made while 32 bytes are waiting is discarded and never sent.
- R5: A read at offset 0x018 returns the status flags: bit 7 is set when the queue is empty, bit 5 when it holds 32 bytes, and bit 3 when the transmitter is busy. All other bits read 0.
- R6: The control register is at offset 0x030. Bit 0 is the master enable and bit 8 is the transmit enable. Both bits read back where they were written, and all other bits read 0. A new frame starts only while both enable bits are 1.
- R7: The busy flag rises with the start bit of the first frame. It stays set across frames sent back to back. It falls exactly one bit period after the final stop bit begins.
- R8: If the queue still holds data when a stop bit ends, the next start bit begins on the very next cycle. Consecutive frame starts are then exactly ten bit periods apart.
- R9: After reset, `tx_out` is 1, the flag register reads 0x80, and the control register reads 0.
- R10: Clearing an enable bit during a frame lets that frame finish. No further frame starts, and the queued bytes are kept for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| baud_tick | input | 1 | Bit-rate strobe, one cycle wide |
| tx_out | output | 1 | Serial output |

## Verification
A queue pointer or count that goes wrong shows at the serial line within one frame, about ten bit periods. Bytes come out in the wrong order, come out twice, or go missing. A miscounted depth also shows in the flag register: the full flag appears on the wrong write in a 33-write burst. A framer state error shows as a start-bit spacing other than ten bit periods, or as a stop bit that reads 0. It can also show as a busy flag that falls early or late. Each of these is visible during the frame in which the error happens.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  localparam int ADDR_W = 12;
  localparam int BUS_W  = 32;
  localparam int DATA_W = 8;
  localparam int FRAME_W = DATA_W + 2;

  localparam logic [ADDR_W-1:0] OFF_DATA = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_FLAG = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h030;

  localparam int FLAG_BUSY_BIT  = 3;
  localparam int FLAG_FULL_BIT  = 5;
  localparam int FLAG_EMPTY_BIT = 7;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_TXEN_BIT  = 8;

  typedef enum logic {FR_IDLE, FR_SEND} fr_state_t;

  // Shift image, sent from bit 0 upward: start, data LSB first, stop.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  function automatic logic [BUS_W-1:0] pack_flags(input logic busy, input logic full,
                                                  input logic empty);
    logic [BUS_W-1:0] w;
    w = '0;
    w[FLAG_BUSY_BIT]  = busy;
    w[FLAG_FULL_BIT]  = full;
    w[FLAG_EMPTY_BIT] = empty;
    return w;
  endfunction

  function automatic logic [BUS_W-1:0] pack_ctrl(input logic en, input logic txen);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]   = en;
    w[CTRL_TXEN_BIT] = txen;
    return w;
  endfunction
endpackage

// File: rtl/txq_fifo.sv
`timescale 1ns/1ps
module txq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                pop_data,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
endmodule

// File: rtl/tx_bit_clock.sv
`timescale 1ns/1ps
module tx_bit_clock #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic bit_stb
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign bit_stb = tick_in;
    end else begin : g_divide
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] sub;
      always_ff @(posedge clk) begin
        if (!rst_n)              sub <= '0;
        else if (tick_in)        sub <= (sub == DW'(TICK_DIV-1)) ? '0 : sub + DW'(1);
      end
      assign bit_stb = tick_in && (sub == DW'(TICK_DIV-1));
    end
  endgenerate
endmodule

// File: rtl/tx_framer.sv
`timescale 1ns/1ps
module tx_framer
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              go,
  input  logic              have_data,
  input  logic [DATA_W-1:0] data,
  output logic              pop,
  output logic              frame_done,
  output logic              busy,
  output logic              tx
);
  localparam int IW = $clog2(FRAME_W);

  fr_state_t          state;
  logic [FRAME_W-1:0] shreg;
  logic [IW-1:0]      idx;
  logic               last_bit, start_ok;

  assign last_bit   = (state == FR_SEND) && (idx == IW'(FRAME_W-1));
  assign frame_done = bit_stb && last_bit;
  assign start_ok   = bit_stb && go && have_data && ((state == FR_IDLE) || last_bit);
  assign pop        = start_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= FR_IDLE;
      shreg <= '1;
      idx   <= '0;
      tx    <= 1'b1;
    end else if (start_ok) begin
      state <= FR_SEND;
      shreg <= build_frame(data);
      idx   <= '0;
      tx    <= 1'b0;
    end else if (frame_done) begin
      state <= FR_IDLE;
      shreg <= '1;
      tx    <= 1'b1;
    end else if ((state == FR_SEND) && bit_stb) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      idx   <= idx + IW'(1);
      tx    <= shreg[1];
    end
  end

  assign busy = (state == FR_SEND);
endmodule

// File: rtl/uart_tx_mmio.sv
`timescale 1ns/1ps
module uart_tx_mmio
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int TICK_DIV   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              baud_tick,
  output logic              tx_out
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  logic              ctrl_en, ctrl_txen, tx_go;
  logic              wr_data, wr_ctrl;
  logic              fifo_full, fifo_empty;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [DATA_W-1:0] fifo_head;
  logic              fr_pop, fr_busy, frame_done, bit_stb;

  assign wr_data = bus_we && (bus_addr == OFF_DATA);
  assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
  assign tx_go   = ctrl_en && ctrl_txen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_txen <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en   <= bus_wdata[CTRL_EN_BIT];
      ctrl_txen <= bus_wdata[CTRL_TXEN_BIT];
    end
  end

  txq_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(wr_data), .push_data(bus_wdata[DATA_W-1:0]),
    .pop(fr_pop), .pop_data(fifo_head),
    .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
  );

  tx_bit_clock #(.TICK_DIV(TICK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .tick_in(baud_tick), .bit_stb(bit_stb)
  );

  tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .go(tx_go),
    .have_data(!fifo_empty), .data(fifo_head),
    .pop(fr_pop), .frame_done(frame_done), .busy(fr_busy), .tx(tx_out)
  );

  always_comb begin
    case (bus_addr)
      OFF_FLAG: bus_rdata = pack_flags(fr_busy, fifo_full, fifo_empty);
      OFF_CTRL: bus_rdata = pack_ctrl(ctrl_en, ctrl_txen);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_tx_mmio_chk.sv
`timescale 1ns/1ps
module uart_tx_mmio_chk #(
  parameter int FIFO_DEPTH = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           tx_out,
  input logic                           busy,
  input logic                           fifo_full,
  input logic                           fifo_empty,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
  input logic                           pop,
  input logic                           frame_done,
  input logic                           tx_go
);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));
  // R4
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);
  // R5
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_empty);
  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_out);
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out);
  // R8
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && tx_go && !fifo_empty) |=> (busy && !tx_out));
  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_done));
  // R6
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_go && !busy) |=> !busy);
endmodule

bind uart_tx_mmio uart_tx_mmio_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_out(tx_out), .busy(fr_busy),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt),
  .pop(fr_pop), .frame_done(frame_done), .tx_go(tx_go)
);

// File: tb/tb_uart_tx_mmio.sv
`timescale 1ns/1ps
module tb_uart_tx_mmio;
  localparam int P = 8;          // cycles per bit (tick period)
  localparam int FRAME = 10 * P;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        baud_tick = 1'b0;
  logic        tx_out;

  uart_tx_mmio dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                    .baud_tick(baud_tick), .tx_out(tx_out));

  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    baud_tick = (cyc % P == 0);
  end

  // stimulus: written word, byte expected on the wire (R3: upper bits ignored)
  localparam logic [39:0] VEC [8] = '{
    {32'h0000_0041, 8'h41}, {32'hFFFF_FF00, 8'h00}, {32'h0000_00FF, 8'hFF},
    {32'h1234_5655, 8'h55}, {32'hA5A5_A5AA, 8'hAA}, {32'h0000_0180, 8'h80},
    {32'hDEAD_BE01, 8'h01}, {32'h7FFF_FF3C, 8'h3C}};

  // serial monitor
  logic [7:0] rx_q [128];
  longint     st_t [128];
  int         rx_cnt = 0, st_cnt = 0;
  initial forever begin
    logic [7:0] b;
    @(negedge clk);
    if (rst_n && tx_out === 1'b0) begin
      st_t[st_cnt] = cyc;
      st_cnt++;
      repeat (4) @(negedge clk);
      chk(tx_out === 1'b0, "R1 start bit", {31'd0, tx_out}, 0);
      for (int k = 0; k < 8; k++) begin
        repeat (P) @(negedge clk);
        b[k] = tx_out;
      end
      repeat (P) @(negedge clk);
      chk(tx_out === 1'b1, "R1 stop bit", {31'd0, tx_out}, 1);
      rx_q[rx_cnt] = b;
      rx_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_rx(input int target);
    int lim = 0;
    while (rx_cnt < target && lim < 20000) begin
      @(negedge clk); lim++;
    end
  endtask

  // drain with flags held on the bus; checks busy never drops mid-burst (R7)
  task automatic drain_watch(input int target, input int first_start);
    int gaps = 0, lim = 0;
    longint fall_t = 0;
    bus_addr = 12'h018;
    while (st_cnt <= first_start && lim < 20000) begin @(negedge clk); lim++; end
    while (rx_cnt < target && lim < 40000) begin
      @(negedge clk); lim++;
      if (!bus_rdata[3] && rx_cnt < target - 1) gaps++;
    end
    while (bus_rdata[3] && lim < 40000) begin @(negedge clk); lim++; end
    fall_t = cyc;
    chk(gaps == 0, "R7 busy held between frames", gaps, 0);
    chk(fall_t - st_t[st_cnt-1] == FRAME, "R7 busy fall after last stop",
        fall_t - st_t[st_cnt-1], FRAME);
  endtask

  initial begin
    logic [31:0] r;
    int base, sbase;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(tx_out === 1'b1, "R9 tx after reset", {31'd0, tx_out}, 1);
    rd(12'h018, r); chk(r == 32'h80, "R9 flags after reset", r, 32'h80);
    rd(12'h030, r); chk(r == 32'h0, "R9 ctrl after reset", r, 0);

    // R6 control readback
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h030, r); chk(r == 32'h101, "R6 ctrl readback", r, 32'h101);
    wr(12'h030, 32'h1);
    rd(12'h030, r); chk(r == 32'h1, "R6 enable only", r, 32'h1);

    // table: load while transmit enable is off, then enable
    base = rx_cnt; sbase = st_cnt;
    foreach (VEC[i]) wr(12'h000, VEC[i][39:8]);
    repeat (20 * P) @(negedge clk);
    chk(rx_cnt == base, "R6 no frame with txen clear", rx_cnt - base, 0);
    chk(tx_out === 1'b1, "R2 idle high while gated", {31'd0, tx_out}, 1);
    rd(12'h018, r); chk(r == 32'h0, "R5 flags queued, idle", r, 0);
    wr(12'h030, 32'h100);
    repeat (20 * P) @(negedge clk);
    chk(rx_cnt == base, "R6 no frame with en clear", rx_cnt - base, 0);
    wr(12'h030, 32'h101);
    drain_watch(base + 8, sbase);
    for (int i = 0; i < 8; i++)
      chk(rx_q[base+i] == VEC[i][7:0], "R3 R1 byte on wire", rx_q[base+i], VEC[i][7:0]);
    for (int i = 1; i < 8; i++)
      chk(st_t[sbase+i] - st_t[sbase+i-1] == FRAME, "R8 start spacing",
          st_t[sbase+i] - st_t[sbase+i-1], FRAME);
    rd(12'h018, r); chk(r == 32'h80, "R5 flags after drain", r, 32'h80);
    chk(tx_out === 1'b1, "R2 idle high after drain", {31'd0, tx_out}, 1);

    // R4 overflow: 33 writes with transmit disabled
    wr(12'h030, 32'h0);
    base = rx_cnt; sbase = st_cnt;
    for (int i = 0; i < 32; i++) begin
      wr(12'h000, 32'h10 + i);
      if (i == 30) begin
        rd(12'h018, r); chk(r == 32'h0, "R5 not full at 31", r, 0);
      end
    end
    rd(12'h018, r); chk(r == 32'h20, "R5 full at 32", r, 32'h20);
    wr(12'h000, 32'hEE);
    rd(12'h018, r); chk(r == 32'h20, "R4 still full after 33rd", r, 32'h20);
    wr(12'h030, 32'h101);
    drain_watch(base + 32, sbase);
    repeat (30 * P) @(negedge clk);
    chk(rx_cnt - base == 32, "R4 33rd byte dropped", rx_cnt - base, 32);
    for (int i = 0; i < 32; i++)
      chk(rx_q[base+i] == 8'(8'h10 + i), "R4 order", rx_q[base+i], 8'(8'h10 + i));
    rd(12'h018, r); chk(r == 32'h80, "R5 empty after overflow drain", r, 32'h80);

    // R10 disable during a frame
    base = rx_cnt; sbase = st_cnt;
    wr(12'h000, 32'h5A); wr(12'h000, 32'hC3); wr(12'h000, 32'h0F);
    while (st_cnt == sbase) @(negedge clk);
    wr(12'h030, 32'h0);
    repeat (40 * P) @(negedge clk);
    chk(rx_cnt - base == 1, "R10 current frame finishes only", rx_cnt - base, 1);
    chk(rx_q[base] == 8'h5A, "R10 finished byte", rx_q[base], 8'h5A);
    rd(12'h018, r); chk(r == 32'h0, "R10 queue kept, not busy", r, 0);
    wr(12'h030, 32'h101);
    wait_rx(base + 3);
    chk(rx_q[base+1] == 8'hC3 && rx_q[base+2] == 8'h0F, "R10 kept bytes sent later",
        {rx_q[base+1], rx_q[base+2]}, 16'hC30F);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule